// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block drives an external SRAM or peripheral device over a 16-line bus that carries both address and data. An internal requester (a DMA engine or register access path) raises `req_valid` with a direction, a 24-bit address and write data, and holds them until `req_ack`. The block then runs one access. First it latches the address into an external latch with the `ale` strobe. It then turns the lines around for a single strobed data cycle. Last it returns a one-cycle acknowledge, together with read data when the access is a read.

Two width modes exist. In wide (16-bit) mode one address cycle carries address bits 15..0 and the data cycle moves 16 bits. In narrow (8-bit) mode a second address cycle carries address bits 23..16, so 24-bit devices can be reached, and only the low byte of data is used. The mode input is sampled once, when the request is accepted. Every access takes at least three clock cycles from acceptance to acknowledge.

Top module: `muxbus_master`

## Requirements
- R1: Out of reset: `ale`=0, `rd_n`=1, `wr_n`=1, `bus_ad_oe`=0, `req_ack`=0.
- R2: A request is accepted at a clock edge where the block is idle and `req_valid`=1. In the next cycle `ale`=1, `bus_ad_oe`=1 and `bus_ad_o`=`req_addr[15:0]`.
- R3: In narrow mode (`wide_mode`=0 at acceptance) a second cycle with `ale`=1 follows. It drives `bus_ad_o`={8'h00, `req_addr[23:16]`}.
- R4: In wide mode (`wide_mode`=1) the strobe cycle follows the single address cycle directly, and `req_addr[23:16]` has no effect on the bus.
- R5: A write (`req_write`=1) holds `wr_n`=0 for one cycle with `bus_ad_oe`=1. The bus carries `req_wdata` in wide mode, or {8'h00, `req_wdata[7:0]`} in narrow mode.
- R6: A read (`req_write`=0) holds `rd_n`=0 for one cycle, with `bus_ad_oe`=0 throughout that cycle.
- R7: `rd_n` and `wr_n` are never low together, and `ale` is never high while either strobe is low.
- R8: Read data is captured from `bus_ad_i` at the edge where `rd_n` returns high. `rsp_rdata` is that value in wide mode, or {8'h00, low byte} in narrow mode, and it is valid while `req_ack`=1.
- R9: `req_ack` is high for exactly one cycle. It comes 3 cycles after acceptance in wide mode and 4 in narrow mode, in the cycle right after the strobe.
- R10: A change of `wide_mode` after acceptance has no effect on the access in progress.
- R11: Changes to `req_addr`, `req_wdata` and `req_write` after acceptance have no effect until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| wide_mode | input | 1 | 1 = 16-bit external width, 0 = 8-bit |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with acknowledge |
| bus_ad_o | output | 16 | Shared address/data lines, driven value |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| bus_ad_i | input | 16 | Shared address/data lines, sampled value |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
A wrong sequencer state appears at the pins within one cycle. A skipped or repeated address phase shows up as an `ale` pulse of the wrong length or with the wrong byte. A stale direction shows up as the bus being driven during `rd_n`, or as the wrong strobe. The bench compares every cycle of each access, from acceptance to acknowledge, against the sequence computed from the mode and direction. A lost mode or capture register therefore fails in the very access where it goes wrong, through the count of address cycles, the acknowledge cycle, or the zero-extended read byte.

// File: rtl/muxbus_master.sv
module muxbus_master #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int STROBE_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          wide_mode,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic [DW-1:0] rsp_rdata,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_i,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n
);
  localparam int HW = DW / 2;
  localparam int CW = $clog2(STROBE_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ALE_LO, S_ALE_HI, S_STROBE, S_DONE} state_t;

  state_t        st;
  logic          wr_q, wide_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [CW-1:0] cnt;

  wire strobe_last = (st == S_STROBE) && (cnt == CW'(STROBE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cnt     <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_ALE_LO;
          wr_q    <= req_write;
          wide_q  <= wide_mode;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
        S_ALE_LO: begin
          st  <= wide_q ? S_STROBE : S_ALE_HI;
          cnt <= '0;
        end
        S_ALE_HI: st <= S_STROBE;
        S_STROBE: begin
          cnt <= cnt + 1'b1;
          if (strobe_last) begin
            st <= S_DONE;
            if (!wr_q)
              rdata_q <= wide_q ? bus_ad_i : {{HW{1'b0}}, bus_ad_i[HW-1:0]};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ale       = (st == S_ALE_LO) || (st == S_ALE_HI);
  assign rd_n      = !((st == S_STROBE) && !wr_q);
  assign wr_n      = !((st == S_STROBE) && wr_q);
  assign bus_ad_oe = ale || !wr_n;
  assign req_ack   = (st == S_DONE);
  assign rsp_rdata = rdata_q;

  always_comb begin
    bus_ad_o = '0;
    case (st)
      S_ALE_LO: bus_ad_o = addr_q[DW-1:0];
      S_ALE_HI: bus_ad_o = DW'(addr_q[AW-1:DW]);
      S_STROBE: if (wr_q) bus_ad_o = wide_q ? wdata_q : {{HW{1'b0}}, wdata_q[HW-1:0]};
      default:  bus_ad_o = '0;
    endcase
  end
endmodule

module muxbus_master_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic bus_ad_oe,
  input logic req_ack
);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
  // R7
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) ale |-> (rd_n && wr_n));
  // R6
  read_float_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !bus_ad_oe);
  // R2
  ale_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) ale |-> bus_ad_oe);
  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ack |=> !req_ack);
  // R9
  ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ack) |-> $past(!rd_n || !wr_n));
endmodule

bind muxbus_master muxbus_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .bus_ad_oe(bus_ad_oe), .req_ack(req_ack)
);

// File: tb/muxbus_master_tb.sv
module muxbus_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, wide_mode = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0, bus_ad_i = '0;
  logic        req_ack, bus_ad_oe, ale, rd_n, wr_n;
  logic [15:0] rsp_rdata, bus_ad_o;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  muxbus_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .wide_mode(wide_mode), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata), .bus_ad_o(bus_ad_o),
    .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  // {write, wide, addr[23:0], data[15:0]}
  localparam logic [41:0] VEC [8] = '{
    {1'b1, 1'b1, 24'hA51234, 16'hBEEF},
    {1'b0, 1'b1, 24'h00FFFF, 16'h1357},
    {1'b1, 1'b0, 24'h7F0042, 16'hC3A5},
    {1'b0, 1'b0, 24'hE1ABCD, 16'h9A6C},
    {1'b1, 1'b0, 24'h000000, 16'hFFFF},
    {1'b0, 1'b1, 24'hFF0001, 16'h8001},
    {1'b0, 1'b0, 24'hFFFFFF, 16'hFFFF},
    {1'b1, 1'b1, 24'h5A5A5A, 16'h0000}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ctrl = {ale, rd_n, wr_n, oe, ack}
  function automatic logic [4:0] ctrl();
    return {ale, rd_n, wr_n, bus_ad_oe, req_ack};
  endfunction

  task automatic access(input logic w, input logic wide, input logic [23:0] a,
                        input logic [15:0] d, input logic flip_mode, input logic flip_req);
    logic [15:0] exp_bus;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; wide_mode = wide; req_addr = a;
    req_wdata = d; bus_ad_i = d;
    @(negedge clk);
    chk(ctrl() == 5'b11110 && bus_ad_o == a[15:0], "R2", {ctrl(), bus_ad_o}, {5'b11110, a[15:0]});
    if (flip_mode) wide_mode = ~wide;
    if (flip_req) begin req_addr = ~a; req_wdata = ~d; req_write = ~w; end
    if (!wide) begin
      @(negedge clk);
      chk(ctrl() == 5'b11110 && bus_ad_o == {8'h00, a[23:16]}, flip_mode ? "R10" : (flip_req ? "R11" : "R3"),
          {ctrl(), bus_ad_o}, {5'b11110, 8'h00, a[23:16]});
    end
    @(negedge clk);
    if (w) begin
      exp_bus = wide ? d : {8'h00, d[7:0]};
      chk(ctrl() == 5'b01010 && bus_ad_o == exp_bus, flip_req ? "R11" : "R5",
          {ctrl(), bus_ad_o}, {5'b01010, exp_bus});
    end else begin
      chk(ctrl() == 5'b00100, wide ? "R4" : "R6", ctrl(), 5'b00100);
    end
    @(negedge clk);
    chk(ctrl() == 5'b01101, "R9", ctrl(), 5'b01101);
    if (!w) chk(rsp_rdata == (wide ? d : {8'h00, d[7:0]}), "R8", rsp_rdata, wide ? d : {8'h00, d[7:0]});
    req_valid = 1'b0;
    @(negedge clk);
    chk(ctrl() == 5'b01100, "R9", ctrl(), 5'b01100);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(ctrl() == 5'b01100, "R1", ctrl(), 5'b01100);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl() == 5'b01100, "R1", ctrl(), 5'b01100);
    for (int i = 0; i < 8; i++)
      access(VEC[i][41], VEC[i][40], VEC[i][39:16], VEC[i][15:0], 1'b0, 1'b0);
    // R10: mode flips after acceptance, both directions
    access(1'b1, 1'b0, 24'h3C2211, 16'h77AA, 1'b1, 1'b0);
    access(1'b0, 1'b1, 24'h3C2211, 16'h77AA, 1'b1, 1'b0);
    // R11: request fields change after acceptance
    access(1'b1, 1'b0, 24'h96ABCD, 16'h1234, 1'b0, 1'b1);
    access(1'b1, 1'b1, 24'h96ABCD, 16'h1234, 1'b0, 1'b1);
    // R4: upper address bits never reach the bus in wide mode
    access(1'b0, 1'b1, 24'hFF0000, 16'h00FF, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule